// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Interface

This block is the digital front end of a two-channel voltage-output converter. A host writes 24-bit frames over a three-wire serial link: an active-low frame select, a serial clock and a data line. All three pins, the load strobe and the clear input are first brought into the system clock domain. Serial bits are taken on falling serial-clock edges while the frame is open. Each channel has two registers. The input register buffers a written value. The DAC register holds the code that drives the converter.

Outputs can follow writes in two ways. In frame-synchronous operation the load strobe is held low, and a completed frame writes the DAC register directly. In strobe-gated operation the load strobe is held high. Frames then fill only the input registers, and a falling edge on the strobe moves both channels to the DAC registers together. A falling edge on the clear input forces every register to a fixed code, which is zero scale or mid-scale as chosen by a parameter. The same code is loaded at reset. The clear also cancels any frame in progress and raises a clear-mode flag. That flag stays set until a later frame completes.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset, both DAC codes equal the power-on code and the clear-mode flag is low. The power-on code is zero when MID_RESET=0 and 2^(RES-1) when MID_RESET=1.
- R2: Frame bits are sent most significant first. Bits 23:22 are the command, and 2'b00 means write. Bits 21:19 are the channel address: 3'b000 selects channel A, 3'b001 selects B and 3'b111 selects both. Bits 18:3 form a left-justified 16-bit data field, and its top RES bits are the code. Bits 2:0 are ignored.
- R3: A frame that closes (select returns high) after fewer than 24 falling clock edges changes no register.
- R4: If the synchronised load strobe is low when a frame completes, each addressed channel gets the new code in both its input register and its DAC register.
- R5: If the load strobe is high when a frame completes, only the input registers change. A later falling edge of the strobe copies both input registers into the DAC registers at once.
- R6: A falling edge on the clear input loads the fixed code into all four registers and sets the clear-mode flag. It also aborts the frame in progress, so the remaining edges of that frame have no effect.
- R7: The clear-mode flag falls only on the 24th falling edge of a later frame, whatever that frame's command or address.
- R8: Falling clock edges after the 24th in one frame are ignored until select goes high again.
- R9: A clear edge and a strobe falling edge seen in the same cycle leave the clear code in place. The clear takes priority.
- R10: A completed frame whose command is not 2'b00, or whose address is not one of the three listed values, changes no data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame select |
| sclk_in | input | 1 | Serial clock; bits are taken on its falling edge |
| din | input | 1 | Serial data |
| load_n | input | 1 | Load strobe: held low for frame-synchronous updates; a falling edge applies the input registers |
| clear_n | input | 1 | Clear input, acting on its falling edge |
| dac_a | output | RES | Active code of channel A |
| dac_b | output | RES | Active code of channel B |
| clear_mode | output | 1 | High while the clear code is in force |

## Verification
The assertions assume the serial pins change slowly compared with the system clock. Each level of sclk_in, and each setup before a change of sync_n, must last several system cycles, so every serial edge turns into exactly one synchronised event. The stimulus holds each serial half period for four clock cycles, moves sync_n only while the serial clock is high, and pulses clear_n and load_n for four cycles. The random part of the stimulus uses a fixed seed. It draws commands, addresses, data and load-strobe modes. Directed cases cover short frames, over-long frames, a clear in the middle of a frame, and a clear together with a strobe edge.

// File: rtl/serial_dac_pkg.sv
package serial_dac_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CMD_W      = 2;
  localparam int ADDR_W     = 3;
  localparam int FIELD_W    = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [CMD_W-1:0] {
    CMD_WRITE = 2'b00,
    CMD_RSV1  = 2'b01,
    CMD_RSV2  = 2'b10,
    CMD_RSV3  = 2'b11
  } cmd_e;

  localparam logic [ADDR_W-1:0] ADDR_CH_A  = 3'b000;
  localparam logic [ADDR_W-1:0] ADDR_CH_B  = 3'b001;
  localparam logic [ADDR_W-1:0] ADDR_BOTH  = 3'b111;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int          W     = 5,
  parameter logic [W-1:0] RST_V = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] lvl
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_V[i];
        s2_q <= RST_V[i];
      end else begin
        s1_q <= pins[i];
        s2_q <= s1_q;
      end
    end
    assign lvl[i] = s2_q;
  end
endmodule

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import serial_dac_pkg::*;
#(
  parameter int RES = 16,
  localparam int OUT_W = CMD_W + ADDR_W + RES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic             abort,
  output logic             done,
  output logic [OUT_W-1:0] frame
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  lock_q, lock_d;
  logic                  done_q, done_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    lock_d = lock_q;
    done_d = 1'b0;
    if (sel_n) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (abort) begin
      cnt_d  = '0;
      lock_d = 1'b1;
    end else if (bit_stb && !lock_q) begin
      sh_d  = {sh_q[FRAME_BITS-2:0], bit_val};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
        lock_d = 1'b1;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
      done_q <= done_d;
    end
  end

  assign done  = done_q;
  assign frame = sh_q[FRAME_BITS-1 -: OUT_W];
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import serial_dac_pkg::*;
#(
  parameter int             RES      = 16,
  parameter int             NCH      = 2,
  parameter logic [RES-1:0] CLR_CODE = '0,
  localparam int            IN_W     = CMD_W + ADDR_W + RES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    done,
  input  logic [IN_W-1:0]         frame,
  input  logic                    sync_mode,
  input  logic                    ld_fall,
  input  logic                    clr_fall,
  output logic [NCH-1:0][RES-1:0] inp,
  output logic [NCH-1:0][RES-1:0] dac,
  output logic                    clr_flag
);
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic [RES-1:0]    code;
  logic              is_write;

  assign cmd      = frame[IN_W-1 -: CMD_W];
  assign addr     = frame[RES +: ADDR_W];
  assign code     = frame[RES-1:0];
  assign is_write = done && (cmd_e'(cmd) == CMD_WRITE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [RES-1:0] inp_q, inp_d, dac_q, dac_d;
    logic           hit;

    assign hit = is_write &&
                 ((addr == ADDR_W'(c)) || (addr == ADDR_BOTH));

    always_comb begin
      inp_d = inp_q;
      dac_d = dac_q;
      if (clr_fall) begin
        inp_d = CLR_CODE;
        dac_d = CLR_CODE;
      end else begin
        if (ld_fall)
          dac_d = inp_q;
        if (hit) begin
          inp_d = code;
          if (sync_mode) dac_d = code;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inp_q <= CLR_CODE;
        dac_q <= CLR_CODE;
      end else begin
        inp_q <= inp_d;
        dac_q <= dac_d;
      end
    end

    assign inp[c] = inp_q;
    assign dac[c] = dac_q;
  end

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_fall)  flag_d = 1'b1;
    else if (done) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign clr_flag = flag_q;
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend
  import serial_dac_pkg::*;
#(
  parameter int RES       = 16,
  parameter bit MID_RESET = 1'b0,
  localparam int NCH      = 2,
  localparam logic [RES-1:0] CLR_CODE =
    MID_RESET ? (RES'(1) << (RES - 1)) : '0,
  localparam int HDR_W    = CMD_W + ADDR_W + RES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sync_n,
  input  logic           sclk_in,
  input  logic           din,
  input  logic           load_n,
  input  logic           clear_n,
  output logic [RES-1:0] dac_a,
  output logic [RES-1:0] dac_b,
  output logic           clear_mode
);
  // pin order: 0 select, 1 data, 2 serial clock, 3 load strobe, 4 clear
  logic [4:0] lvl;
  logic [2:0] falls;

  pin_sync #(.W(5), .RST_V(5'b11101)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pins ({clear_n, load_n, sclk_in, din, sync_n}),
    .lvl  (lvl)
  );

  fall_detect #(.W(3)) u_edges (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl[4:2]),
    .fall (falls)
  );

  logic sck_fall, ld_fall, clr_fall;
  assign sck_fall = falls[0];
  assign ld_fall  = falls[1];
  assign clr_fall = falls[2];

  logic             frame_done;
  logic [HDR_W-1:0] frame_word;

  frame_shifter #(.RES(RES)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n  (lvl[0]),
    .bit_stb(sck_fall),
    .bit_val(lvl[1]),
    .abort  (clr_fall),
    .done   (frame_done),
    .frame  (frame_word)
  );

  logic [NCH-1:0][RES-1:0] inp_regs, dac_regs;

  dac_reg_bank #(.RES(RES), .NCH(NCH), .CLR_CODE(CLR_CODE)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (frame_done),
    .frame    (frame_word),
    .sync_mode(~lvl[3]),
    .ld_fall  (ld_fall),
    .clr_fall (clr_fall),
    .inp      (inp_regs),
    .dac      (dac_regs),
    .clr_flag (clear_mode)
  );

  assign dac_a = dac_regs[0];
  assign dac_b = dac_regs[1];
endmodule

// File: rtl/serial_dac_frontend_chk.sv
module serial_dac_frontend_chk #(
  parameter int             RES      = 16,
  parameter logic [RES-1:0] CLR_CODE = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_done,
  input logic               ld_fall,
  input logic               clr_fall,
  input logic [1:0][RES-1:0] inp_regs,
  input logic [1:0][RES-1:0] dac_regs,
  input logic               clear_mode
);
  // R3 and R4: DAC registers only move on a completed frame, a strobe or a clear
  assert_dac_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done || ld_fall || clr_fall) |=> $stable(dac_regs));

  // R5: input registers only move on a completed frame or a clear
  assert_inp_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done || clr_fall) |=> $stable(inp_regs));

  // R6 and R9: clear loads every register and raises the flag
  assert_clear_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (dac_regs == {CLR_CODE, CLR_CODE}) &&
                 (inp_regs == {CLR_CODE, CLR_CODE}) && clear_mode);

  // R5: strobe edge copies the buffered codes
  assert_strobe_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && !clr_fall && !frame_done) |=> dac_regs == $past(inp_regs));

  // R7: clear mode is left only through a completed frame
  assert_clear_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clear_mode) |-> $past(frame_done));
endmodule

bind serial_dac_frontend serial_dac_frontend_chk #(
  .RES(RES), .CLR_CODE(CLR_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_done(frame_done),
  .ld_fall   (ld_fall),
  .clr_fall  (clr_fall),
  .inp_regs  (inp_regs),
  .dac_regs  (dac_regs),
  .clear_mode(clear_mode)
);

// File: tb/serial_dac_frontend_test.sv
module serial_dac_frontend_test;
  localparam int RES = 16;
  localparam bit MID = 1'b0;
  localparam logic [RES-1:0] CODE = MID ? (RES'(1) << (RES - 1)) : '0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, sclk_in = 1'b1, din = 1'b0, load_n = 1'b0, clear_n = 1'b1;
  logic [RES-1:0] dac_a, dac_b;
  logic clear_mode;

  always #5 clk = ~clk;

  serial_dac_frontend #(.RES(RES), .MID_RESET(MID)) uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk_in(sclk_in),
    .din(din), .load_n(load_n), .clear_n(clear_n),
    .dac_a(dac_a), .dac_b(dac_b), .clear_mode(clear_mode)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [RES-1:0] m_inp [2];
  logic [RES-1:0] m_dac [2];
  logic           m_flag;

  function automatic logic [RES-1:0] code_of(input logic [23:0] w);
    logic [15:0] f = w[18:3];
    return f[15 -: RES];
  endfunction

  function automatic logic [23:0] mk(input logic [1:0] c, input logic [2:0] a,
                                     input logic [15:0] d);
    return {c, a, d, 3'b101};
  endfunction

  task automatic model_frame(input logic [23:0] w);
    for (int ch = 0; ch < 2; ch++) begin
      if (w[23:22] == 2'b00 && (w[21:19] == 3'(ch) || w[21:19] == 3'b111)) begin
        m_inp[ch] = code_of(w);
        if (!load_n) m_dac[ch] = code_of(w);
      end
    end
    m_flag = 1'b0;
  endtask

  task automatic check(input string tag);
    n_vec++;
    if (dac_a !== m_dac[0] || dac_b !== m_dac[1] || clear_mode !== m_flag) begin
      n_bad++;
      $display("FAIL %s: got a=%h b=%h clr=%b expected a=%h b=%h clr=%b",
               tag, dac_a, dac_b, clear_mode, m_dac[0], m_dac[1], m_flag);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    clear_n = 1'b0; wait_clk(4); clear_n = 1'b1;
    for (int ch = 0; ch < 2; ch++) begin m_inp[ch] = CODE; m_dac[ch] = CODE; end
    m_flag = 1'b1;
  endtask

  task automatic set_load(input logic v);
    if (load_n && !v) begin m_dac[0] = m_inp[0]; m_dac[1] = m_inp[1]; end
    load_n = v;
    wait_clk(6);
  endtask

  // nedges falling serial edges; clr_at >= 0 inserts a clear before that edge
  task automatic send(input logic [23:0] w, input int nedges, input int clr_at);
    wait_clk(1);
    sync_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nedges; i++) begin
      if (i == clr_at) begin pulse_clear(); wait_clk(4); end
      din = (i < 24) ? w[23 - i] : ~w[0];
      sclk_in = 1'b1; wait_clk(4);
      sclk_in = 1'b0; wait_clk(4);
    end
    sclk_in = 1'b1; wait_clk(4);
    sync_n = 1'b1;
    wait_clk(8);
    if (nedges >= 24 && clr_at < 0) model_frame(w);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    void'($urandom(32'd4242));
    for (int ch = 0; ch < 2; ch++) begin m_inp[ch] = CODE; m_dac[ch] = CODE; end
    m_flag = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 reset state");

    // R2 and R4: sync mode writes to A, B, both
    send(mk(2'b00, 3'b000, 16'hA55A), 24, -1); check("R2 R4 write A");
    send(mk(2'b00, 3'b001, 16'h1234), 24, -1); check("R2 R4 write B");
    send(mk(2'b00, 3'b111, 16'hBEEF), 24, -1); check("R2 R4 write both");

    // R3: short frame discarded
    send(mk(2'b00, 3'b000, 16'h0F0F), 20, -1); check("R3 short frame");
    send(mk(2'b00, 3'b001, 16'h7777), 23, -1); check("R3 23 edges");

    // R8: extra edges ignored
    send(mk(2'b00, 3'b000, 16'hC3C3), 30, -1); check("R8 long frame");

    // R10: other commands and addresses
    send(mk(2'b01, 3'b000, 16'h1111), 24, -1); check("R10 reserved command");
    send(mk(2'b00, 3'b010, 16'h2222), 24, -1); check("R10 unused address");

    // R5: strobe-gated mode
    set_load(1'b1);
    send(mk(2'b00, 3'b000, 16'h4321), 24, -1); check("R5 buffered A");
    send(mk(2'b00, 3'b001, 16'h8765), 24, -1); check("R5 buffered B");
    set_load(1'b0); check("R5 strobe applies both");

    // R6: clear, and abort of a frame in progress
    pulse_clear(); wait_clk(6); check("R6 clear code");
    send(mk(2'b00, 3'b111, 16'h5A5A), 24, 10); check("R6 aborted frame");
    // R7: a short frame does not exit; a full one does
    send(mk(2'b00, 3'b000, 16'h6666), 12, -1); check("R7 short keeps clear");
    send(mk(2'b10, 3'b000, 16'h6666), 24, -1); check("R7 full frame exits");

    // R9: clear and strobe together
    set_load(1'b1);
    send(mk(2'b00, 3'b111, 16'h9999), 24, -1); check("R9 setup");
    clear_n = 1'b0; load_n = 1'b0;
    for (int ch = 0; ch < 2; ch++) begin m_inp[ch] = CODE; m_dac[ch] = CODE; end
    m_flag = 1'b1;
    wait_clk(4); clear_n = 1'b1; wait_clk(6);
    check("R9 clear beats strobe");

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [2:0] a;
      int r = $urandom_range(0, 9);
      a = (r < 3) ? 3'b000 : (r < 6) ? 3'b001 : (r < 8) ? 3'b111 : 3'($urandom);
      w = mk(($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b00, a, 16'($urandom));
      if ($urandom_range(0, 5) == 0) set_load(~load_n);
      if ($urandom_range(0, 9) == 0) begin pulse_clear(); wait_clk(6); end
      send(w, ($urandom_range(0, 6) == 0) ? $urandom_range(1, 23) : 24, -1);
      check("R2 R4 R5 random");
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule